// File: doc/BRIEF.md
# PHY Register Handshake Master

This block lets a host read or write one 16-bit PHY register at a time. The PHY registers are not memory-mapped. They are reached through a side channel made of a 20-bit control word, driven by this block, and a 17-bit status word, returned by the PHY. Every step of an access is a complete four-phase exchange: the block raises a strobe, waits for the acknowledge flag to go high, drops the strobe and waits for the flag to go low again.

The host presents an address, write data when needed, and a direction bit for one cycle while the block is idle. The block then runs the required phases and ends with a one-cycle done pulse. A read also returns the captured data. Each acknowledge wait is bounded: the flag is sampled at a fixed spacing, derived from a cycles-per-microsecond parameter, up to a limited number of times. If the expected level never appears, the block abandons the access and flags an error.

Top module: `phy_reg_hs_master`

## Requirements
- R1: After reset the control word is zero, busy, done and err are low, and the read-data output is zero.
- R2: Control word layout: bits 15:0 carry the address or data field, bit 16 is the address-capture strobe, bit 17 the data-capture strobe, bit 18 the write strobe and bit 19 the read strobe. At most one strobe is high in any cycle.
- R3: Every access begins with an address phase. The address is driven on bits 15:0 with no strobe for one cycle, then the address-capture strobe is raised with the field unchanged. After acknowledge goes high the strobe is dropped while the address stays on the field, and the block waits for acknowledge to go low.
- R4: A write then puts the data on the field for one cycle and runs a data-capture handshake with the data held. Next comes a write-strobe handshake: bit 18 is set alone, and when it is released the data is on the field again. After the final acknowledge-low the control word returns to zero.
- R5: A read, after the address phase, raises the read strobe alone. When acknowledge is seen high it captures status bits 15:0 into the read-data output and drives the control word to zero, then waits for acknowledge low. Status bit 16 is the acknowledge flag.
- R6: Each wait samples acknowledge in the first cycle after the control word changes and then every CYC_PER_US cycles, at most POLL_LIMIT times. The wait ends on the first sample that shows the expected level.
- R7: If the last permitted sample does not show the expected level, the control word goes to zero, done and err pulse together on the next cycle, and the block returns to idle without running any later phase.
- R8: A request is taken only while the block is idle. Busy is high from the cycle after acceptance up to the cycle in which done pulses. A request presented while busy is ignored.
- R9: Done lasts exactly one cycle, and err is never high without done.
- R10: After a timeout, the next request completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, accepted when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | PHY register address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Timeout, valid with done |
| rdata | output | 16 | Data from the last successful read |
| phy_ctrl | output | 20 | Control word to the PHY |
| phy_stat | input | 17 | Status word from the PHY |

## Verification
The bench sweeps the responder's acknowledge delay from one cycle up to the last permitted sample and one step past it. For each delay it checks the end-to-end latency, which shows whether sampling happens on the poll grid. A design that polled off that grid, or allowed one sample too many or too few, would finish a cycle too early or too late, or would time out at the boundary delay. Other tests refuse one particular strobe or hold acknowledge stuck high. Here a design that kept going after a timeout would commit a write that should never land, and one that failed to clear its wait state would hang or mis-time the recovery access. A request injected mid-access must leave both the latency and the memory unchanged; otherwise the design restarted or corrupted the access.

// File: rtl/phy_hs_pkg.sv
package phy_hs_pkg;
  // Field widths and strobe positions are fixed by the PHY side channel.
  localparam int unsigned FLD_W    = 16;
  localparam int unsigned BIT_CAPA = FLD_W;
  localparam int unsigned BIT_CAPD = FLD_W + 1;
  localparam int unsigned BIT_WR   = FLD_W + 2;
  localparam int unsigned BIT_RD   = FLD_W + 3;
  localparam int unsigned CTRL_W   = FLD_W + 4;
  localparam int unsigned STAT_W   = FLD_W + 1;
  localparam int unsigned BIT_ACK  = FLD_W;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR_SET,
    ST_ADDR_CAP,
    ST_ADDR_REL,
    ST_DATA_SET,
    ST_DATA_CAP,
    ST_DATA_REL,
    ST_WR_ON,
    ST_WR_REL,
    ST_RD_ON,
    ST_RD_REL
  } hs_state_e;
endpackage

// File: rtl/phy_hs_poll.sv
module phy_hs_poll #(
  parameter int unsigned CYC_PER_US = 50,
  parameter int unsigned POLL_LIMIT = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic ack,
  input  logic expect_lvl,
  output logic hit,
  output logic expire
);
  localparam int unsigned CYC_W = $clog2(CYC_PER_US + 1);
  localparam int unsigned TRY_W = $clog2(POLL_LIMIT + 1);

  logic [CYC_W-1:0] cyc_q, cyc_d;
  logic [TRY_W-1:0] try_q, try_d;
  logic             sample;
  logic             cnt_en;

  assign sample = active && (cyc_q == '0);
  assign hit    = sample && (ack == expect_lvl);
  assign expire = sample && (ack != expect_lvl) &&
                  (try_q == TRY_W'(POLL_LIMIT - 1));
  assign cnt_en = active || (cyc_q != '0) || (try_q != '0);

  always_comb begin
    cyc_d = cyc_q;
    try_d = try_q;
    if (!active || hit || expire) begin
      cyc_d = '0;
      try_d = '0;
    end else if (cyc_q == CYC_W'(CYC_PER_US - 1)) begin
      cyc_d = '0;
      try_d = try_q + 1'b1;
    end else begin
      cyc_d = cyc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= '0;
      try_q <= '0;
    end else if (cnt_en) begin
      cyc_q <= cyc_d;
      try_q <= try_d;
    end
  end

  // R6: never more than POLL_LIMIT samples inside one wait
  a_r6_try_bound: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (try_q < TRY_W'(POLL_LIMIT)));

  // R6: a wait that has been left starts the next one from a clean count
  a_r6_fresh_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (hit || expire) |=> (cyc_q == '0 && try_q == '0));
endmodule

// File: rtl/phy_hs_seq.sv
module phy_hs_seq
  import phy_hs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [FLD_W-1:0]  req_addr,
  input  logic [FLD_W-1:0]  req_wdata,
  input  logic              hit,
  input  logic              expire,
  input  logic [FLD_W-1:0]  stat_data,
  output logic              wait_active,
  output logic              expect_lvl,
  output logic [CTRL_W-1:0] ctrl,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [FLD_W-1:0]  rdata
);
  hs_state_e         state_q, state_d;
  logic [FLD_W-1:0]  addr_q, wdata_q, rdata_q;
  logic              wr_q;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic              done_q, err_q;
  logic              accept, finish, fail, cap_rd, ctrl_en;
  logic [FLD_W-1:0]  addr_src, data_src;

  function automatic logic [CTRL_W-1:0] ctrl_of(hs_state_e st,
                                                logic [FLD_W-1:0] a,
                                                logic [FLD_W-1:0] d);
    logic [CTRL_W-1:0] w;
    w = '0;
    case (st)
      ST_ADDR_SET, ST_ADDR_REL: w[FLD_W-1:0] = a;
      ST_ADDR_CAP: begin
        w[FLD_W-1:0] = a;
        w[BIT_CAPA]  = 1'b1;
      end
      ST_DATA_SET, ST_DATA_REL, ST_WR_REL: w[FLD_W-1:0] = d;
      ST_DATA_CAP: begin
        w[FLD_W-1:0] = d;
        w[BIT_CAPD]  = 1'b1;
      end
      ST_WR_ON: w[BIT_WR] = 1'b1;
      ST_RD_ON: w[BIT_RD] = 1'b1;
      default:  w = '0;
    endcase
    return w;
  endfunction

  assign accept   = req_valid && (state_q == ST_IDLE);
  assign addr_src = accept ? req_addr  : addr_q;
  assign data_src = accept ? req_wdata : wdata_q;

  always_comb begin
    wait_active = 1'b0;
    expect_lvl  = 1'b0;
    case (state_q)
      ST_ADDR_CAP, ST_DATA_CAP, ST_WR_ON, ST_RD_ON: begin
        wait_active = 1'b1;
        expect_lvl  = 1'b1;
      end
      ST_ADDR_REL, ST_DATA_REL, ST_WR_REL, ST_RD_REL: wait_active = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    state_d = state_q;
    finish  = 1'b0;
    fail    = 1'b0;
    cap_rd  = 1'b0;
    case (state_q)
      ST_IDLE:     if (accept) state_d = ST_ADDR_SET;
      ST_ADDR_SET: state_d = ST_ADDR_CAP;
      ST_ADDR_CAP: if (hit) state_d = ST_ADDR_REL;
      ST_ADDR_REL: if (hit) state_d = wr_q ? ST_DATA_SET : ST_RD_ON;
      ST_DATA_SET: state_d = ST_DATA_CAP;
      ST_DATA_CAP: if (hit) state_d = ST_DATA_REL;
      ST_DATA_REL: if (hit) state_d = ST_WR_ON;
      ST_WR_ON:    if (hit) state_d = ST_WR_REL;
      ST_WR_REL: if (hit) begin
        state_d = ST_IDLE;
        finish  = 1'b1;
      end
      ST_RD_ON: if (hit) begin
        state_d = ST_RD_REL;
        cap_rd  = 1'b1;
      end
      ST_RD_REL: if (hit) begin
        state_d = ST_IDLE;
        finish  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
    if (wait_active && expire) begin
      state_d = ST_IDLE;
      fail    = 1'b1;
    end
  end

  assign ctrl_d  = ctrl_of(state_d, addr_src, data_src);
  assign ctrl_en = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ctrl_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= finish || fail;
      err_q   <= fail;
      if (ctrl_en) ctrl_q <= ctrl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      wr_q    <= req_write;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (cap_rd) rdata_q <= stat_data;
  end

  assign ctrl  = ctrl_q;
  assign busy  = (state_q != ST_IDLE);
  assign done  = done_q;
  assign err   = err_q;
  assign rdata = rdata_q;

  // R2: strobes are mutually exclusive
  a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ctrl_q[CTRL_W-1:FLD_W]) <= 1);

  // R3: capture strobe rises with the field already in place
  a_r3_rise_field_stable: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ctrl_q[BIT_CAPA]) || $rose(ctrl_q[BIT_CAPD])) |->
      $stable(ctrl_q[FLD_W-1:0]));

  // R3: address is kept on the field when the capture strobe drops
  a_r3_fall_field_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ctrl_q[BIT_CAPA]) && busy) |-> $stable(ctrl_q[FLD_W-1:0]));

  // R7: idle always presents an all-zero control word
  a_r7_idle_ctrl_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> (ctrl_q == '0));

  // R8: busy only ends with a done pulse
  a_r8_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done_q));

  // R9: done is a single-cycle pulse
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R9: error is only reported alongside done
  a_r9_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> done_q);
endmodule

// File: rtl/phy_reg_hs_master.sv
module phy_reg_hs_master
  import phy_hs_pkg::*;
#(
  parameter int unsigned CYC_PER_US = 50,
  parameter int unsigned POLL_LIMIT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [FLD_W-1:0]  req_addr,
  input  logic [FLD_W-1:0]  req_wdata,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [FLD_W-1:0]  rdata,
  output logic [CTRL_W-1:0] phy_ctrl,
  input  logic [STAT_W-1:0] phy_stat
);
  logic wait_active;
  logic expect_lvl;
  logic hit;
  logic expire;

  phy_hs_poll #(
    .CYC_PER_US(CYC_PER_US),
    .POLL_LIMIT(POLL_LIMIT)
  ) poll_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (wait_active),
    .ack       (phy_stat[BIT_ACK]),
    .expect_lvl(expect_lvl),
    .hit       (hit),
    .expire    (expire)
  );

  phy_hs_seq seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .hit        (hit),
    .expire     (expire),
    .stat_data  (phy_stat[FLD_W-1:0]),
    .wait_active(wait_active),
    .expect_lvl (expect_lvl),
    .ctrl       (phy_ctrl),
    .busy       (busy),
    .done       (done),
    .err        (err),
    .rdata      (rdata)
  );

  // R7: an expired wait ends the access with error and a cleared control word
  a_r7_expire_ends: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (done && err && !busy && phy_ctrl == '0));

  // R6: the poller is only counting while a wait is in progress
  a_r6_wait_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wait_active |-> busy);
endmodule

// File: tb/phy_reg_hs_master_tb_top.sv
module phy_reg_hs_master_tb_top;
  localparam int C = 3;
  localparam int L = 5;
  localparam int LAST = (L - 1) * C;

  logic        clk;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [15:0] req_addr, req_wdata;
  logic        busy, done, err;
  logic [15:0] rdata;
  logic [19:0] phy_ctrl;
  logic [16:0] phy_stat;

  int n_chk = 0;
  int n_bad = 0;
  int proto_bad = 0;

  phy_reg_hs_master #(.CYC_PER_US(C), .POLL_LIMIT(L)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
    .err(err), .rdata(rdata), .phy_ctrl(phy_ctrl), .phy_stat(phy_stat)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [15:0] init_val(int i);
    return 16'(32'hC000 + i * 291);
  endfunction

  // ---------------- responder model ----------------
  logic        ack_r;
  logic [15:0] rsp_data;
  logic [15:0] rmem [16];
  logic [15:0] a_full, d_l;
  int          cnt, rises;
  int          rsp_dly = 1;
  int          refuse_rise = 0;
  int          refuse_fall = 0;
  logic        rsp_clr = 1'b0;
  logic        tgt;

  assign tgt      = |phy_ctrl[19:16];
  assign phy_stat = {ack_r, rsp_data};

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_r    <= 1'b0;
      cnt      <= 0;
      rises    <= 0;
      a_full   <= 16'h0;
      d_l      <= 16'h0;
      rsp_data <= 16'h0;
      for (int i = 0; i < 16; i++) rmem[i] <= init_val(i);
    end else if (rsp_clr) begin
      ack_r <= 1'b0;
      cnt   <= 0;
      rises <= 0;
    end else if (tgt == ack_r) begin
      cnt <= 0;
    end else if (tgt && refuse_rise == rises + 1) begin
      cnt <= 0;
    end else if (!tgt && refuse_fall != 0 && refuse_fall == rises) begin
      cnt <= 0;
    end else if (cnt + 1 >= rsp_dly) begin
      ack_r <= tgt;
      cnt   <= 0;
      if (tgt) begin
        rises <= rises + 1;
        if (phy_ctrl[16]) a_full <= phy_ctrl[15:0];
        if (phy_ctrl[17]) d_l    <= phy_ctrl[15:0];
        if (phy_ctrl[18]) rmem[a_full[3:0]] <= d_l;
        if (phy_ctrl[19]) rsp_data <= rmem[a_full[3:0]];
      end
    end else begin
      cnt <= cnt + 1;
    end
  end

  // R2 monitor: more than one strobe at once is a protocol error
  always @(negedge clk) begin
    if (rst_n && $countones(phy_ctrl[19:16]) > 1) proto_bad <= proto_bad + 1;
  end

  // ---------------- checking ----------------
  logic [15:0] exp_mem [16];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run(input bit wr, input logic [15:0] addr, input logic [15:0] data,
                     input bit poke, output int k, output logic [15:0] rd, output logic e);
    bit busy_ok;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = data;
    @(posedge clk);
    k = 1;
    @(negedge clk);
    req_valid = 1'b0;
    busy_ok = 1'b1;
    while (!done && k < 500) begin
      if (!busy) busy_ok = 1'b0;
      if (poke && k == 3) begin
        req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h0006; req_wdata = 16'hDEAD;
      end else begin
        req_valid = 1'b0;
      end
      @(posedge clk); k++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    rd = rdata;
    e  = err;
    chk("R8 busy held until done", {31'h0, busy_ok}, 32'h1);
    chk("R8 busy low at done", {31'h0, busy}, 32'h0);
    @(negedge clk);
    chk("R9 done single cycle", {31'h0, done}, 32'h0);
    chk("R4/R7 control word zero after access", {12'h0, phy_ctrl}, 32'h0);
  endtask

  task automatic pulse_clr();
    @(negedge clk); rsp_clr = 1'b1;
    @(negedge clk); rsp_clr = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int k, m;
    logic [15:0] rd, a, d;
    logic e;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    for (int i = 0; i < 16; i++) exp_mem[i] = init_val(i);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1 ctrl", {12'h0, phy_ctrl}, 32'h0);
    chk("R1 busy/done/err", {29'h0, busy, done, err}, 32'h0);
    chk("R1 rdata", {16'h0, rdata}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 R4 R5 R6: delay sweep up to the last permitted sample
    for (int dly = 1; dly <= LAST; dly++) begin
      rsp_dly = dly;
      m = (dly + C - 1) / C;
      a = 16'((dly << 8) | dly);
      d = 16'((dly * 16'h1357) ^ 16'hA0A0);
      run(1'b1, a, d, 1'b0, k, rd, e);
      exp_mem[dly] = d;
      chk("R6 write latency", k, 3 + 6 * (m * C + 1));
      chk("R4 write no error", {31'h0, e}, 32'h0);
      chk("R3 captured address on write", {16'h0, a_full}, {16'h0, a});
      chk("R4 write landed", {16'h0, rmem[dly]}, {16'h0, d});
      run(1'b0, a, 16'h0, 1'b0, k, rd, e);
      chk("R6 read latency", k, 2 + 4 * (m * C + 1));
      chk("R5 read data", {16'h0, rd}, {16'h0, d});
      chk("R5 read no error", {31'h0, e}, 32'h0);
      chk("R3 captured address on read", {16'h0, a_full}, {16'h0, a});
    end

    // R5: untouched registers read back their power-up contents
    rsp_dly = 1;
    for (int i = 13; i < 16; i++) begin
      run(1'b0, 16'(i), 16'h0, 1'b0, k, rd, e);
      chk("R5 untouched read", {16'h0, rd}, {16'h0, exp_mem[i]});
    end

    // R6 R7: acknowledge one cycle past the last sample -> timeout
    rsp_dly = LAST + 1;
    run(1'b0, 16'h0001, 16'h0, 1'b0, k, rd, e);
    chk("R7 timeout latency", k, 3 + LAST);
    chk("R7 timeout error", {31'h0, e}, 32'h1);

    // R10: recovery
    rsp_dly = 1;
    run(1'b0, 16'h0001, 16'h0, 1'b0, k, rd, e);
    chk("R10 recovery data", {16'h0, rd}, {16'h0, exp_mem[1]});
    chk("R10 recovery no error", {31'h0, e}, 32'h0);

    // R7: write strobe never acknowledged -> no later phase, memory untouched
    refuse_rise = 3;
    pulse_clr();
    run(1'b1, 16'h0002, 16'hBEEF, 1'b0, k, rd, e);
    chk("R7 write-phase timeout latency", k, 4 + 4 * (C + 1) + LAST);
    chk("R7 write-phase error", {31'h0, e}, 32'h1);
    refuse_rise = 0;
    pulse_clr();
    run(1'b0, 16'h0002, 16'h0, 1'b0, k, rd, e);
    chk("R7 aborted write not applied", {16'h0, rd}, {16'h0, exp_mem[2]});

    // R7: acknowledge stuck high after the read strobe
    refuse_fall = 2;
    pulse_clr();
    run(1'b0, 16'h0003, 16'h0, 1'b0, k, rd, e);
    chk("R7 stuck-high latency", k, 3 + 3 * (C + 1) + LAST);
    chk("R7 stuck-high error", {31'h0, e}, 32'h1);
    refuse_fall = 0;
    pulse_clr();
    run(1'b0, 16'h0003, 16'h0, 1'b0, k, rd, e);
    chk("R10 read after stuck-high", {16'h0, rd}, {16'h0, exp_mem[3]});
    chk("R10 no error after stuck-high", {31'h0, e}, 32'h0);

    // R8: request while busy is ignored
    run(1'b1, 16'h0005, 16'h5A5A, 1'b1, k, rd, e);
    exp_mem[5] = 16'h5A5A;
    chk("R8 latency unaffected by mid-access request", k, 3 + 6 * (C + 1));
    run(1'b0, 16'h0006, 16'h0, 1'b0, k, rd, e);
    chk("R8 ignored request wrote nothing", {16'h0, rd}, {16'h0, exp_mem[6]});
    run(1'b0, 16'h0005, 16'h0, 1'b0, k, rd, e);
    chk("R8 original write intact", {16'h0, rd}, {16'h0, 16'h5A5A});

    chk("R2 at most one strobe", proto_bad, 32'h0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule